// File: doc/BRIEF.md
# Framebuffer Fill and Swap Controller

This block drives a pair of 16-bit framebuffers. One buffer is on screen and the other is the back buffer, which the CPU draws into. Software sets a fill length, a start address and a pattern. Writing the pattern starts a hardware fill of the back buffer at one word per clock. The fill address steps only in its low byte, so a fill wraps inside a 256-word line. When the fill ends, the address after the last word is left in the start register, so the next fill can continue from there.

A frame-select bit chooses which buffer is shown. All fills and CPU drawing go to the other buffer. A new frame-select value takes effect straight away when vertical blanking is active or the display mode is zero. Otherwise the value is held as a pending request and is applied on the next rising edge of blanking. A mode register carries the display mode and a priority bit. Any change of the priority bit sends a one-cycle pulse that tells the palette logic its contents are stale.

Top module: `fb_fill_swap`

## Requirements
- R1: After reset, all of these are zero: busy, write enable, frame select, pending flag, display mode, priority, fill length, start address and the palette-stale pulse.
- R2: Writing the pattern register (select code 3) while idle sets busy and writes N+1 words, one per clock, where N is the fill-length register (select code 1, bits [7:0]). Busy stays high for exactly those N+1 cycles.
- R3: Every word of a fill carries the pattern that was written. The first word goes to the address held in the start register (select code 2, bits [15:0]).
- R4: From one fill word to the next, address bits [7:0] increase by one and wrap from 0xFF to 0x00. Bits [15:8] stay fixed.
- R5: When a fill ends, the start register holds the first address after the last word written. That value is visible on fill_start_o in the first idle cycle.
- R6: The fill write port targets the buffer opposite the shown one, so mem_bank_o is the inverse of fs_o.
- R7: A write to the frame register (select code 4, bit 0) takes effect on fs_o in the next cycle if vblank_i is high or the display mode (select code 0, bits [1:0]) is zero.
- R8: In any other case, a frame-register write leaves fs_o unchanged and raises fs_pending_o while the requested value differs from the shown one.
- R9: A pending frame select is applied on the first clock at which vblank_i is seen high after being low. fs_pending_o then clears.
- R10: A mode-register write that changes the priority bit (bit 7) raises pal_dirty_o for exactly one cycle. A write that keeps the bit unchanged does not raise it.
- R11: A pattern-register write during a running fill is ignored. The pattern, the word count and the final address are those of the running fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 mode, 1 length, 2 start, 3 pattern, 4 frame |
| wr_data_i | input | 16 | Register write data |
| vblank_i | input | 1 | Vertical blanking status |
| busy_o | output | 1 | Fill in progress |
| mem_we_o | output | 1 | Back-buffer write enable |
| mem_bank_o | output | 1 | Buffer index targeted by the write port |
| mem_addr_o | output | 16 | Back-buffer word address |
| mem_data_o | output | 16 | Back-buffer write data |
| fill_start_o | output | 16 | Start register contents |
| fill_len_o | output | 8 | Fill-length register contents |
| fs_o | output | 1 | Buffer currently shown |
| fs_pending_o | output | 1 | A frame-select request is waiting for blanking |
| disp_mode_o | output | 2 | Display mode field |
| prio_o | output | 1 | Priority bit |
| pal_dirty_o | output | 1 | One-cycle palette-stale pulse |

## Verification
Register writes land on the clock edge that samples the strobe. The first fill word, an immediate frame change and the palette pulse are therefore all visible in the half cycle that follows that edge. Later fill words follow one per cycle. The written-back start address and the drop of busy appear N+1 edges after the pattern write. A pending frame select resolves one edge after vblank_i is driven high. The bench drives inputs on falling edges and samples outputs on the falling edge after the responsible rising edge. For every fill it counts one expected word per cycle from the pattern write.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_LEN   = 3'd1,
    REG_START = 3'd2,
    REG_DATA  = 3'd3,
    REG_FRAME = 3'd4
  } reg_sel_e;

  localparam int MODE_W    = 2;
  localparam int PRIO_BIT  = 7;
  localparam int FRAME_BIT = 0;
endpackage

// File: rtl/fb_fill_seq.sv
module fb_fill_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] pattern_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] end_addr_o
);
  localparam int HI_W = ADDR_W - LINE_W;

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [DATA_W-1:0] pat_q;
  logic [ADDR_W-1:0] addr_nx;

  // low part wraps inside the line, high part fixed
  assign addr_nx = {addr_q[ADDR_W-1:LINE_W], addr_q[LINE_W-1:0] + LINE_W'(1)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      pat_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        addr_q <= start_addr_i;
        left_q <= len_i;
        pat_q  <= pattern_i;
      end
    end else begin
      addr_q <= addr_nx;
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - LEN_W'(1);
    end
  end

  assign busy_o     = busy_q;
  assign addr_o     = addr_q;
  assign data_o     = pat_q;
  assign done_o     = busy_q && (left_q == '0);
  assign end_addr_o = addr_nx;

  p_line_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && left_q != '0) |=>
      (addr_q[LINE_W-1:0] == $past(addr_q[LINE_W-1:0]) + LINE_W'(1)) &&
      (addr_q[ADDR_W-1:LINE_W] == $past(addr_q[ADDR_W-1:LINE_W])));

  p_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> busy_q);

  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(pat_q));

  initial begin
    p_geom_r4: assert (HI_W > 0);
  end
endmodule

// File: rtl/fb_swap_ctl.sv
module fb_swap_ctl #(
  parameter int MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              fs_i,
  input  logic              vblank_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              fs_o,
  output logic              pending_o
);
  logic vb_q, fs_q, req_q, open;

  assign open = vblank_i || (mode_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_q  <= 1'b0;
      fs_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      vb_q <= vblank_i;
      if (wr_i) begin
        req_q <= fs_i;
        if (open) fs_q <= fs_i;
      end else if (vblank_i && !vb_q) begin
        fs_q <= req_q;
      end
    end
  end

  assign fs_o      = fs_q;
  assign pending_o = fs_q ^ req_q;

  p_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && open) |=> fs_q == $past(fs_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vblank_i && !(wr_i && mode_i == '0)) |=> $stable(fs_q));

  p_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vblank_i && !vb_q && !wr_i) |=> (fs_q == $past(req_q)) && !pending_o);
endmodule

// File: rtl/fb_fill_swap.sv
module fb_fill_swap
  import fb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              vblank_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic              mem_bank_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [ADDR_W-1:0] fill_start_o,
  output logic [LEN_W-1:0]  fill_len_o,
  output logic              fs_o,
  output logic              fs_pending_o,
  output logic [MODE_W-1:0] disp_mode_o,
  output logic              prio_o,
  output logic              pal_dirty_o
);
  logic              wr_mode, wr_len, wr_start, wr_data, wr_frame;
  logic [MODE_W-1:0] mode_q;
  logic              prio_q, dirty_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] start_q;
  logic              seq_busy, seq_done, fs;
  logic [ADDR_W-1:0] seq_addr, seq_end;
  logic [DATA_W-1:0] seq_data;

  assign wr_mode  = wr_en_i && (reg_sel_i == REG_MODE);
  assign wr_len   = wr_en_i && (reg_sel_i == REG_LEN);
  assign wr_start = wr_en_i && (reg_sel_i == REG_START);
  assign wr_data  = wr_en_i && (reg_sel_i == REG_DATA);
  assign wr_frame = wr_en_i && (reg_sel_i == REG_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      prio_q  <= 1'b0;
      dirty_q <= 1'b0;
      len_q   <= '0;
      start_q <= '0;
    end else begin
      dirty_q <= wr_mode && (wr_data_i[PRIO_BIT] != prio_q);
      if (wr_mode) begin
        mode_q <= wr_data_i[MODE_W-1:0];
        prio_q <= wr_data_i[PRIO_BIT];
      end
      if (wr_len) len_q <= wr_data_i[LEN_W-1:0];
      // write-back of the end address wins over a software write
      if (seq_done)      start_q <= seq_end;
      else if (wr_start) start_q <= wr_data_i[ADDR_W-1:0];
    end
  end

  fb_fill_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LINE_W(LINE_W)
  ) i_fill_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (wr_data),
    .start_addr_i (start_q),
    .len_i        (len_q),
    .pattern_i    (wr_data_i),
    .busy_o       (seq_busy),
    .addr_o       (seq_addr),
    .data_o       (seq_data),
    .done_o       (seq_done),
    .end_addr_o   (seq_end)
  );

  fb_swap_ctl #(.MODE_W(MODE_W)) i_swap_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_frame),
    .fs_i      (wr_data_i[FRAME_BIT]),
    .vblank_i  (vblank_i),
    .mode_i    (mode_q),
    .fs_o      (fs),
    .pending_o (fs_pending_o)
  );

  assign busy_o       = seq_busy;
  assign mem_we_o     = seq_busy;
  assign mem_bank_o   = ~fs;
  assign mem_addr_o   = seq_addr;
  assign mem_data_o   = seq_data;
  assign fill_start_o = start_q;
  assign fill_len_o   = len_q;
  assign fs_o         = fs;
  assign disp_mode_o  = mode_q;
  assign prio_o       = prio_q;
  assign pal_dirty_o  = dirty_q;

  p_dirty_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_dirty_o |-> $past(wr_en_i) && ($past(reg_sel_i) == REG_MODE));

  p_dirty_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_dirty_o && !wr_mode) |=> !pal_dirty_o);

  p_writeback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |=> (fill_start_o == $past(seq_end)) && !busy_o);
endmodule

// File: tb/test_fb_fill_swap.sv
module test_fb_fill_swap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] wr_data = '0;
  logic        vblank = 1'b0;
  logic        busy, mem_we, mem_bank, fs, fs_pend, prio, pal_dirty;
  logic [15:0] mem_addr, mem_data, fill_start;
  logic [7:0]  fill_len;
  logic [1:0]  disp_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_fill_swap i_fb_fill_swap (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .reg_sel_i(reg_sel),
    .wr_data_i(wr_data), .vblank_i(vblank), .busy_o(busy), .mem_we_o(mem_we),
    .mem_bank_o(mem_bank), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .fill_start_o(fill_start), .fill_len_o(fill_len), .fs_o(fs),
    .fs_pending_o(fs_pend), .disp_mode_o(disp_mode), .prio_o(prio),
    .pal_dirty_o(pal_dirty)
  );

  // start, length, pattern
  localparam logic [39:0] FILL_VEC [4] = '{
    {16'h1200, 8'd3,  16'hAAAA},
    {16'h34FE, 8'd4,  16'h5555},
    {16'h00FF, 8'd0,  16'h1234},
    {16'hABF0, 8'd31, 16'hFFFF}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the falling edge after the sampling edge
  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_fill(input logic [15:0] st, input logic [7:0] n,
                          input logic [15:0] pat);
    logic [7:0] lo;
    wr(3'd1, {8'h00, n});
    wr(3'd2, st);
    wr(3'd3, pat);
    lo = st[7:0];
    for (int k = 0; k <= int'(n); k++) begin
      chk(busy && mem_we, "R2 busy/we", {busy, mem_we}, 2'b11);
      chk(mem_addr == {st[15:8], lo}, "R4 address", mem_addr, {st[15:8], lo});
      chk(mem_data == pat, "R3 pattern", mem_data, pat);
      chk(mem_bank == ~fs, "R6 bank", mem_bank, ~fs);
      lo = lo + 8'd1;
      @(negedge clk);
    end
    chk(!busy, "R2 busy end", busy, 0);
    chk(fill_start == {st[15:8], lo}, "R5 writeback", fill_start, {st[15:8], lo});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int words;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1 reset state
    chk({busy, mem_we, fs, fs_pend, prio, pal_dirty} == '0, "R1 flags",
        {busy, mem_we, fs, fs_pend, prio, pal_dirty}, 0);
    chk(fill_start == 0 && fill_len == 0 && disp_mode == 0, "R1 regs",
        {fill_start, fill_len, disp_mode}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++)
      run_fill(FILL_VEC[i][39:24], FILL_VEC[i][23:16], FILL_VEC[i][15:0]);

    // R7 immediate while mode is zero
    wr(3'd4, 16'h0001);
    chk(fs == 1 && !fs_pend, "R7 mode0 swap", {fs, fs_pend}, 2'b10);
    wr(3'd0, 16'h0001);
    chk(disp_mode == 1 && !pal_dirty, "R10 no prio change", {disp_mode, pal_dirty}, 3'b010);
    // R8 deferred outside blanking
    wr(3'd4, 16'h0000);
    chk(fs == 1 && fs_pend, "R8 deferred", {fs, fs_pend}, 2'b11);
    repeat (3) @(negedge clk);
    chk(fs == 1 && fs_pend, "R8 held", {fs, fs_pend}, 2'b11);
    // R9 commit on vblank rise
    vblank = 1'b1;
    @(negedge clk);
    chk(fs == 0 && !fs_pend, "R9 commit", {fs, fs_pend}, 2'b00);
    // R7 immediate during blanking
    wr(3'd4, 16'h0001);
    chk(fs == 1 && !fs_pend, "R7 vblank swap", {fs, fs_pend}, 2'b10);
    vblank = 1'b0;
    // R10 priority pulse
    wr(3'd0, 16'h0081);
    chk(pal_dirty && prio, "R10 pulse", {pal_dirty, prio}, 2'b11);
    @(negedge clk);
    chk(!pal_dirty, "R10 one cycle", pal_dirty, 0);
    wr(3'd0, 16'h0081);
    chk(!pal_dirty, "R10 same prio", pal_dirty, 0);

    // R11 pattern write during a fill; fs is 1 so bank is 0 (R6)
    wr(3'd1, 16'h0005);
    wr(3'd2, 16'h2000);
    wr(3'd3, 16'h1111);
    words = 0;
    for (int c = 0; c < 20 && busy; c++) begin
      chk(mem_data == 16'h1111, "R11 pattern kept", mem_data, 16'h1111);
      chk(mem_bank == 1'b0, "R6 bank flip", mem_bank, 0);
      words++;
      if (c == 1) begin
        wr_en = 1'b1; reg_sel = 3'd3; wr_data = 16'h2222;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(words == 6, "R11 word count", words, 6);
    chk(fill_start == 16'h2006, "R11 end address", fill_start, 16'h2006);
    @(negedge clk);
    chk(!busy, "R11 no restart", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule